// File: doc/BRIEF.md
# Audio Sample Requantizer with Monitor Select

This block takes a full-resolution 24-bit signed audio sample and derives the 8-bit signed value that feeds a downstream filter. The 8-bit value is the sample's most significant byte. A runtime count of 0 to 7 low-order bits is then removed from it, either by truncation or by round-to-nearest. The removed bits are forced to zero, so the value keeps its full-scale weight.

The block also picks the 24-bit sample sent to the listener. When the bypass button is held, the listener gets the untouched original. Otherwise a select bit picks either the filter's 8-bit result or the freshly requantized filter input. Either 8-bit value is placed at the top of the 24-bit word. All results are registered and change only on a sample strobe, so control changes take effect on the next sample.

Top module: `requant_monitor`

## Requirements
- R1: While `rstN` is low, and after reset until the first strobe, `filterIn` and `monitorOut` are zero.
- R2: With `roundNearest` low, `filterIn` is `origSample[23:16]` with its `dropBits` least significant bits cleared. For two's-complement values this is rounding toward minus infinity.
- R3: `dropBits` is a natural-binary count from 0 to 7. With a count of 0, `filterIn` equals `origSample[23:16]` in both rounding modes.
- R4: With `roundNearest` high and a count d > 0, the byte has 2^(d-1) added to it and then its low d bits cleared. An exact half therefore rounds toward plus infinity.
- R5: When the round-to-nearest sum exceeds +127, `filterIn` saturates to 0x7F and does not wrap to a negative value.
- R6: When `bypassBtn` is high at a strobe, `monitorOut` becomes that strobe's `origSample`, whatever `selFilter`, `dropBits` and `roundNearest` are.
- R7: When `bypassBtn` is low and `selFilter` is high at a strobe, `monitorOut` becomes `{filterOut, 16'h0000}`.
- R8: When `bypassBtn` and `selFilter` are both low at a strobe, `monitorOut` becomes `{q, 16'h0000}`, where q is the requantized value loaded into `filterIn` on that same strobe.
- R9: Outputs update only on a clock edge where `sampleStrobe` is high. Changes to any other input between strobes leave both outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleStrobe | input | 1 | One-cycle sample strobe; results load on this edge |
| origSample | input | 24 | Full-resolution signed audio sample |
| filterOut | input | 8 | Signed result returned by the filter |
| dropBits | input | 3 | Number of low-order bits removed from the 8-bit value |
| roundNearest | input | 1 | 1 = round to nearest, 0 = truncate |
| selFilter | input | 1 | 1 = monitor the filter result, 0 = monitor the requantized input |
| bypassBtn | input | 1 | 1 = monitor the original 24-bit sample |
| filterIn | output | 8 | Requantized signed value for the filter |
| monitorOut | output | 24 | Sample sent to the listener |

## Verification
The assertions check on every cycle the properties that hold for any sample value. These are: outputs hold between strobes, bypass passes the sample through exactly, the filter result is placed correctly, the low bytes are zero in 8-bit monitor modes, the removed bits are zero, and rounding never turns a non-negative byte negative. The exact values produced by truncation and rounding can only be shown by the bench's scenarios and its per-cycle arithmetic model. These include ties, negative inputs, a count of zero, and saturation at counts 2 and 7.

// File: rtl/requant_pkg.sv
package requant_pkg;

  typedef enum logic [1:0] {
    MON_ORIG = 2'd0,
    MON_REQ  = 2'd1,
    MON_FILT = 2'd2
  } monSel_e;

  typedef struct packed {
    logic    load;
    monSel_e monSel;
  } dpCtrl_t;

endpackage

// File: rtl/requant_ctrl.sv
module requant_ctrl
  import requant_pkg::*;
(
  input  logic    sampleStrobe,
  input  logic    selFilter,
  input  logic    bypassBtn,
  output dpCtrl_t ctrl
);

  always_comb begin
    ctrl.load = sampleStrobe;
    if (bypassBtn)
      ctrl.monSel = MON_ORIG;
    else if (selFilter)
      ctrl.monSel = MON_FILT;
    else
      ctrl.monSel = MON_REQ;
  end

endmodule

// File: rtl/requant_dp.sv
module requant_dp
  import requant_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int Q_W   = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic [IN_W-1:0]  origSample,
  input  logic [Q_W-1:0]   filterOut,
  input  logic [CNT_W-1:0] dropBits,
  input  logic             roundNearest,
  output logic [Q_W-1:0]   filterIn,
  output logic [IN_W-1:0]  monitorOut
);

  localparam int PAD_W = IN_W - Q_W;
  localparam logic [Q_W-1:0] MAX_POS = {1'b0, {(Q_W-1){1'b1}}};

  logic [Q_W-1:0] topVal;
  logic [Q_W-1:0] keepMask;
  logic [Q_W:0]   halfLsb;
  logic [Q_W:0]   roundSum;
  logic           roundOvf;
  logic [Q_W-1:0] truncVal;
  logic [Q_W-1:0] roundVal;
  logic [Q_W-1:0] quantVal;
  logic [IN_W-1:0] monNext;

  assign topVal   = origSample[IN_W-1 -: Q_W];
  assign keepMask = {Q_W{1'b1}} << dropBits;

  always_comb begin
    halfLsb = '0;
    if (dropBits != '0)
      halfLsb = (Q_W+1)'(1) << CNT_W'(dropBits - 1'b1);
  end

  // sign-extended add; overflow only possible upward since halfLsb >= 0
  assign roundSum = {topVal[Q_W-1], topVal} + halfLsb;
  assign roundOvf = roundSum[Q_W] != roundSum[Q_W-1];
  assign truncVal = topVal & keepMask;
  assign roundVal = roundOvf ? MAX_POS : (roundSum[Q_W-1:0] & keepMask);
  assign quantVal = roundNearest ? roundVal : truncVal;

  always_comb begin
    unique case (ctrl.monSel)
      MON_ORIG: monNext = origSample;
      MON_FILT: monNext = {filterOut, {PAD_W{1'b0}}};
      default:  monNext = {quantVal, {PAD_W{1'b0}}};
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filterIn   <= '0;
      monitorOut <= '0;
    end else if (ctrl.load) begin
      filterIn   <= quantVal;
      monitorOut <= monNext;
    end
  end

endmodule

// File: rtl/requant_monitor.sv
module requant_monitor
  import requant_pkg::*;
#(
  parameter int IN_W  = 24,
  parameter int Q_W   = 8,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleStrobe,
  input  logic [IN_W-1:0]  origSample,
  input  logic [Q_W-1:0]   filterOut,
  input  logic [CNT_W-1:0] dropBits,
  input  logic             roundNearest,
  input  logic             selFilter,
  input  logic             bypassBtn,
  output logic [Q_W-1:0]   filterIn,
  output logic [IN_W-1:0]  monitorOut
);

  dpCtrl_t ctrl;

  requant_ctrl i_ctrl (
    .sampleStrobe(sampleStrobe),
    .selFilter   (selFilter),
    .bypassBtn   (bypassBtn),
    .ctrl        (ctrl)
  );

  requant_dp #(.IN_W(IN_W), .Q_W(Q_W), .CNT_W(CNT_W)) i_dp (
    .clk         (clk),
    .rstN        (rstN),
    .ctrl        (ctrl),
    .origSample  (origSample),
    .filterOut   (filterOut),
    .dropBits    (dropBits),
    .roundNearest(roundNearest),
    .filterIn    (filterIn),
    .monitorOut  (monitorOut)
  );

endmodule

// File: rtl/requant_monitor_chk.sv
module requant_monitor_chk #(
  parameter int IN_W  = 24,
  parameter int Q_W   = 8,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleStrobe,
  input logic [IN_W-1:0]  origSample,
  input logic [Q_W-1:0]   filterOut,
  input logic [CNT_W-1:0] dropBits,
  input logic             roundNearest,
  input logic             selFilter,
  input logic             bypassBtn,
  input logic [Q_W-1:0]   filterIn,
  input logic [IN_W-1:0]  monitorOut
);

  localparam int PAD_W = IN_W - Q_W;

  always_comb begin
    if (!rstN) begin
      a_reset_zero_r1: assert (filterIn == '0 && monitorOut == '0);
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStrobe |=> ($stable(filterIn) && $stable(monitorOut)));

  p_bypass_r6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && bypassBtn) |=> (monitorOut == $past(origSample)));

  p_filt_sel_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && !bypassBtn && selFilter) |=>
      (monitorOut == {$past(filterOut), {PAD_W{1'b0}}}));

  p_req_sel_r8: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && !bypassBtn && !selFilter) |=>
      (monitorOut[IN_W-1 -: Q_W] == filterIn && monitorOut[PAD_W-1:0] == '0));

  p_trunc_low_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && !roundNearest) |=>
      ((filterIn & ~({Q_W{1'b1}} << $past(dropBits))) == '0));

  p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && roundNearest && !origSample[IN_W-1]) |=> !filterIn[Q_W-1]);

  p_zero_drop_r3: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStrobe && dropBits == '0) |=> (filterIn == $past(origSample[IN_W-1 -: Q_W])));

endmodule

bind requant_monitor requant_monitor_chk #(.IN_W(IN_W), .Q_W(Q_W), .CNT_W(CNT_W)) i_chk (.*);

// File: tb/test_requant_monitor.sv
module test_requant_monitor;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sampleStrobe = 1'b0;
  logic [23:0] origSample = '0;
  logic [7:0]  filterOut = '0;
  logic [2:0]  dropBits = '0;
  logic        roundNearest = 1'b0;
  logic        selFilter = 1'b0;
  logic        bypassBtn = 1'b0;
  logic [7:0]  filterIn;
  logic [23:0] monitorOut;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0]  expFilt = '0;
  logic [23:0] expMon = '0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  requant_monitor i_requant_monitor (
    .clk(clk), .rstN(rstN), .sampleStrobe(sampleStrobe), .origSample(origSample),
    .filterOut(filterOut), .dropBits(dropBits), .roundNearest(roundNearest),
    .selFilter(selFilter), .bypassBtn(bypassBtn), .filterIn(filterIn),
    .monitorOut(monitorOut)
  );

  function automatic logic [7:0] refQuant(logic [23:0] s, int d, bit rnd);
    int v;
    int r;
    v = $signed(s[23:16]);
    if (d == 0) r = v;
    else if (rnd) begin
      r = v + (1 << (d - 1));
      r = (r >>> d) <<< d;
      if (r > 127) r = 127;
    end else r = (v >>> d) <<< d;
    return r[7:0];
  endfunction

  task automatic compare(string tag);
    vectors++;
    if (filterIn !== expFilt || monitorOut !== expMon) begin
      miscompares++;
      $display("FAIL %s: filterIn=%h monitorOut=%h expected filterIn=%h monitorOut=%h",
               tag, filterIn, monitorOut, expFilt, expMon);
    end
  endtask

  // inputs are driven just after a falling edge; the next rising edge captures
  task automatic step(bit stb, logic [23:0] s, logic [7:0] f, int d, bit rnd,
                      bit sel, bit byp, string tag);
    logic [7:0] q;
    sampleStrobe = stb; origSample = s; filterOut = f; dropBits = 3'(d);
    roundNearest = rnd; selFilter = sel; bypassBtn = byp;
    if (stb) begin
      q = refQuant(s, d, rnd);
      expFilt = q;
      if (byp) expMon = s;
      else if (sel) expMon = {f, 16'h0};
      else expMon = {q, 16'h0};
    end
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1 in reset");
    rstN = 1'b1;
    @(negedge clk);
    compare("R1 after reset");

    // R3: zero drop passes through in both modes
    step(1, 24'h7F1234, 8'h00, 0, 0, 0, 0, "R3 trunc d0");
    step(1, 24'h80ABCD, 8'h00, 0, 1, 0, 0, "R3 round d0");
    // R2: truncation floors, including negatives
    step(1, 24'h370000, 8'h00, 3, 0, 0, 0, "R2 trunc pos");
    step(1, 24'hF90000, 8'h00, 2, 0, 0, 0, "R2 trunc neg");
    step(1, 24'h810000, 8'h00, 7, 0, 0, 0, "R2 trunc d7");
    // R4: rounding, exact half and negatives
    step(1, 24'h060000, 8'h00, 2, 1, 0, 0, "R4 tie up");
    step(1, 24'hFA0000, 8'h00, 2, 1, 0, 0, "R4 neg tie");
    step(1, 24'hF90000, 8'h00, 3, 1, 0, 0, "R4 neg round");
    // R5: saturation
    step(1, 24'h7E0000, 8'h00, 2, 1, 0, 0, "R5 sat d2");
    step(1, 24'h400000, 8'h00, 7, 1, 0, 0, "R5 sat d7");
    step(1, 24'h3F0000, 8'h00, 7, 1, 0, 0, "R5 below sat d7");
    // R6: bypass overrides everything
    step(1, 24'h12ABCD, 8'h55, 5, 1, 1, 1, "R6 bypass sel1");
    step(1, 24'hFEDCBA, 8'h55, 3, 0, 0, 1, "R6 bypass sel0");
    // R7 / R8 monitor selects
    step(1, 24'h123456, 8'hA5, 1, 0, 1, 0, "R7 filter out");
    step(1, 24'h6B0000, 8'h3C, 4, 1, 0, 0, "R8 requant in");
    // R9: no strobe, inputs wiggle, outputs hold
    step(0, 24'hFFFFFF, 8'hFF, 0, 1, 1, 1, "R9 hold a");
    step(0, 24'h000000, 8'h00, 7, 0, 0, 0, "R9 hold b");
    step(1, 24'h000000, 8'h00, 7, 0, 0, 0, "R9 next strobe");

    for (int i = 0; i < 400; i++) begin
      step(($urandom % 3) != 0, 24'($urandom), 8'($urandom), int'($urandom % 8),
           1'($urandom), 1'($urandom), (($urandom % 4) == 0), "R2 R4 R8 mixed");
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule